// File: doc/BRIEF.md
# Parallel Smart-LCD Bus Master

This block drives a smart display panel that holds its own register file and frame memory. It uses an 8080-style parallel bus: an 18-line data bus plus four control lines. Those lines are chip-select, write strobe and read strobe, all active low, and a register-select level that is low for an index (command) cycle and high for a data cycle. A host issues one operation at a time on a request port: an index write, a data write, or a register read. The read runs an index cycle followed by a bus turnaround and a read-strobe cycle. The 16-bit word is spread over the 18-line bus with lines 0 and 9 left unused.

Each bus phase lasts a number of clocks taken from a 16-bit timing word. That word is captured when the request is accepted. A single state machine steps through its phases. IDLE waits for a request and moves to SETUP on acceptance. SETUP (select low, bus driven, strobe high) moves to STROBE. STROBE (write low) moves to HOLD (write high, bus still driven). HOLD returns to IDLE for a write, or moves to TURN for a read. TURN (bus released, register-select high) moves to RD_ACT (read strobe low, data sampled in its last clock). RD_ACT moves to RD_HOLD (read strobe high, select still low), which returns to IDLE. Every phase lasts its timing field plus one clock, except TURN, which always lasts one clock.

Top module: `lcd_bus_master`

## Requirements
- R1: While the bus is driven, word bits 7..0 appear on lines 8..1 and bits 15..8 on lines 17..10, and lines 0 and 9 are low.
- R2: Read data is rebuilt from bus lines 8..1 (low byte) and 17..10 (high byte); lines 0 and 9 have no effect on rd_word.
- R3: req_op 00 is an index write (register-select low during the strobe), 01 is a data write (register-select high), and 10 or 11 is a register read.
- R4: timing_cfg holds command setup in bits 3..0, command hold in 7..4, data setup in 11..8 and data hold in 15..12. A write keeps select low with the strobe high for setup+1 clocks, holds the write strobe low for setup+1 clocks, then keeps the bus driven with the strobe high for hold+1 clocks. Index cycles use the command fields and data cycles use the data fields.
- R5: A read first runs an index cycle (register-select low, command timing, the index on the bus). It then releases the bus and raises register-select for one clock, drives the read strobe low for data setup+1 clocks, and keeps select low with the read strobe high for data hold+1 clocks.
- R6: The bus output enable is low whenever the read strobe is low, and it drops at least one clock before the read strobe falls.
- R7: busy is high from the clock after acceptance until chip-select returns high. done is a one-clock pulse in the clock where chip-select returns high. A request while busy is ignored.
- R8: After reset all strobes are high, register-select is high, the bus is not driven, and busy, done and rd_word are zero.
- R9: timing_cfg is captured at acceptance, so later changes do not alter a running transfer. rd_word holds the last read value until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus timing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 2 | Operation: 00 index, 01 data, 1x read |
| req_word | input | 16 | Register number or data value |
| timing_cfg | input | 16 | Phase lengths, four 4-bit fields |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| rd_word | output | 16 | Last value read from the panel |
| lcd_cs_n | output | 1 | Chip-select, active low |
| lcd_rs | output | 1 | Register-select: low index, high data |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_dout | output | 18 | Bus value driven by the master |
| lcd_dout_en | output | 1 | Bus output enable |
| lcd_din | input | 18 | Bus value seen at the pads |

## Verification
The hardest situation to reach from the ports is a second request arriving while a transfer is in flight. The bench drives it in the middle of a data write with an index op and a distinct word, then confirms that the panel index and the bus stay untouched. The bench also has to tell apart bus values sampled at the right and wrong moments. Its panel model drives a junk pattern whenever the read strobe is high and sets lines 0 and 9 high during the strobe, so an early sample or a wrong unpacking shows up in rd_word. The timing word is changed right after acceptance to expose any use of the live value.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;
    localparam int TF_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_TURN, ST_RD_ACT, ST_RD_HOLD
    } lcd_state_e;

    typedef struct packed {
        logic [TF_W-1:0] dhold;
        logic [TF_W-1:0] dsetup;
        logic [TF_W-1:0] chold;
        logic [TF_W-1:0] csetup;
    } lcd_timing_t;

    localparam logic [1:0] OP_INDEX = 2'b00;
    localparam logic [1:0] OP_DATA  = 2'b01;
endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/lcd_word_pack.sv
module lcd_word_pack #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W+1:0] bus_out,
    input  logic [WORD_W+1:0] bus_in,
    output logic [WORD_W-1:0] word_out
);
    localparam int HALF = WORD_W / 2;

    logic unused_pad_bits;

    // Line 0 and line HALF+1 carry nothing; each byte sits one line above a gap.
    assign bus_out  = {word_in[WORD_W-1:HALF], 1'b0, word_in[HALF-1:0], 1'b0};
    assign word_out = {bus_in[WORD_W+1:HALF+2], bus_in[HALF:1]};
    assign unused_pad_bits = bus_in[0] ^ bus_in[HALF+1];
endmodule

// File: rtl/lcd_bus_master.sv
module lcd_bus_master
    import lcd_bus_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [WORD_W-1:0] req_word,
    input  logic [4*TF_W-1:0] timing_cfg,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rd_word,
    output logic              lcd_cs_n,
    output logic              lcd_rs,
    output logic              lcd_wr_n,
    output logic              lcd_rd_n,
    output logic [WORD_W+1:0] lcd_dout,
    output logic              lcd_dout_en,
    input  logic [WORD_W+1:0] lcd_din
);
    localparam int BUS_W = WORD_W + 2;
    localparam int GAP   = WORD_W / 2 + 1;

    lcd_state_e        state_q, state_d;
    lcd_timing_t       tm_q, req_tm;
    logic [WORD_W-1:0] word_q, rd_word_q, unpacked;
    logic              is_read_q, is_data_q, done_q;
    logic              ld, expired, accept, finish, capture;
    logic [TF_W-1:0]   ld_val, setup_len, hold_len;

    assign req_tm    = lcd_timing_t'(timing_cfg);
    assign setup_len = is_data_q ? tm_q.dsetup : tm_q.csetup;
    assign hold_len  = is_data_q ? tm_q.dhold  : tm_q.chold;

    lcd_phase_timer #(.CW(TF_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .expired(expired)
    );

    lcd_word_pack #(.WORD_W(WORD_W)) u_pack (
        .word_in(word_q), .bus_out(lcd_dout), .bus_in(lcd_din), .word_out(unpacked)
    );

    // Next-state and phase-length selection
    always_comb begin
        state_d = state_q;
        ld      = 1'b0;
        ld_val  = '0;
        accept  = 1'b0;
        finish  = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                accept  = 1'b1;
                state_d = ST_SETUP;
                ld      = 1'b1;
                ld_val  = (req_op == OP_DATA) ? req_tm.dsetup : req_tm.csetup;
            end
            ST_SETUP: if (expired) begin
                state_d = ST_STROBE;
                ld      = 1'b1;
                ld_val  = setup_len;
            end
            ST_STROBE: if (expired) begin
                state_d = ST_HOLD;
                ld      = 1'b1;
                ld_val  = hold_len;
            end
            ST_HOLD: if (expired) begin
                if (is_read_q) begin
                    state_d = ST_TURN;
                    ld      = 1'b1;
                    ld_val  = '0;
                end else begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            ST_TURN: if (expired) begin
                state_d = ST_RD_ACT;
                ld      = 1'b1;
                ld_val  = tm_q.dsetup;
            end
            ST_RD_ACT: if (expired) begin
                state_d = ST_RD_HOLD;
                capture = 1'b1;
                ld      = 1'b1;
                ld_val  = tm_q.dhold;
            end
            ST_RD_HOLD: if (expired) begin
                state_d = ST_IDLE;
                finish  = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            tm_q      <= '0;
            word_q    <= '0;
            is_read_q <= 1'b0;
            is_data_q <= 1'b0;
            rd_word_q <= '0;
            done_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
            if (accept) begin
                tm_q      <= req_tm;
                word_q    <= req_word;
                is_read_q <= req_op[1];
                is_data_q <= (req_op == OP_DATA);
            end
            if (capture)
                rd_word_q <= unpacked;
        end
    end

    // Pin decode from state
    always_comb begin
        lcd_cs_n    = (state_q == ST_IDLE);
        lcd_wr_n    = (state_q != ST_STROBE);
        lcd_rd_n    = (state_q != ST_RD_ACT);
        lcd_dout_en = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
        unique case (state_q)
            ST_SETUP, ST_STROBE, ST_HOLD: lcd_rs = is_data_q;
            default:                      lcd_rs = 1'b1;
        endcase
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign rd_word = rd_word_q;

    assert_pad_lines_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_dout_en |-> (lcd_dout[0] == 1'b0 && lcd_dout[GAP] == 1'b0));
    assert_rs_high_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rd_n |-> lcd_rs);
    assert_rd_bus_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rd_n |-> !lcd_dout_en);
    assert_turnaround_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_rd_n) |-> $past(!lcd_dout_en));
    assert_strobe_in_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_wr_n || !lcd_rd_n) |-> !lcd_cs_n);
    assert_done_ends_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy && lcd_cs_n));
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lcd_cs_n && lcd_wr_n && lcd_rd_n && !lcd_dout_en));
    assert_word_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({lcd_wr_n, lcd_rd_n}) >= BUS_W - WORD_W - 1);
endmodule

// File: tb/lcd_bus_master_test.sv
`timescale 1ns/1ps
module lcd_bus_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [15:0] req_word = 16'h0;
    logic [15:0] timing_cfg = 16'h0;
    logic        busy, done, lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n, lcd_dout_en;
    logic [15:0] rd_word;
    logic [17:0] lcd_dout, lcd_din;

    int checks = 0, failures = 0;
    logic [15:0] panel_regs [256];
    logic [7:0]  cur_idx = 8'h00;
    int n_setup, n_wr, n_hold, n_turn, n_rd, n_rdhold, busy_err, oe_clash;
    logic [17:0] cap_bus;
    logic        cap_rs;

    always #4 clk = ~clk;

    lcd_bus_master uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_word(req_word), .timing_cfg(timing_cfg), .busy(busy), .done(done),
        .rd_word(rd_word), .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs), .lcd_wr_n(lcd_wr_n),
        .lcd_rd_n(lcd_rd_n), .lcd_dout(lcd_dout), .lcd_dout_en(lcd_dout_en), .lcd_din(lcd_din)
    );

    function automatic logic [17:0] pack_ref(input logic [15:0] w);
        return {w[15:8], 1'b0, w[7:0], 1'b0};
    endfunction

    function automatic logic [15:0] unpack_ref(input logic [17:0] b);
        return {b[17:10], b[8:1]};
    endfunction

    // Panel model: junk outside the read strobe, pad lines set high during it
    assign lcd_din = lcd_rd_n ? 18'h15555 : (pack_ref(panel_regs[cur_idx]) | 18'h00201);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one request and watch the bus until done; optional intruding request
    task automatic run_op(input logic [1:0] op, input logic [15:0] w,
                          input logic [15:0] t, input bit intrude);
        bit seen_wr, seen_rd, applied;
        n_setup = 0; n_wr = 0; n_hold = 0; n_turn = 0; n_rd = 0; n_rdhold = 0;
        busy_err = 0; oe_clash = 0; seen_wr = 0; seen_rd = 0; applied = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_word = w; timing_cfg = t;
        @(negedge clk);
        req_valid = 1'b0;
        timing_cfg = 16'hFFFF;
        for (int k = 0; k < 600; k++) begin
            if (k > 0) @(negedge clk);
            if (intrude && k == 2) begin
                req_valid = 1'b1; req_op = 2'b00; req_word = 16'h0077;
            end else begin
                req_valid = 1'b0;
            end
            if (done) break;
            if (busy !== 1'b1 || lcd_cs_n !== 1'b0) busy_err++;
            if (!lcd_wr_n) begin
                n_wr++; seen_wr = 1; cap_bus = lcd_dout; cap_rs = lcd_rs;
            end else begin
                if (seen_wr && !applied) begin
                    applied = 1;
                    if (!cap_rs) cur_idx = unpack_ref(cap_bus)[7:0];
                    else panel_regs[cur_idx] = unpack_ref(cap_bus);
                end
                if (!lcd_rd_n) begin
                    n_rd++; seen_rd = 1;
                    if (lcd_dout_en) oe_clash++;
                end else if (!seen_wr) n_setup++;
                else if (lcd_dout_en) n_hold++;
                else if (!seen_rd) n_turn++;
                else n_rdhold++;
            end
        end
        req_valid = 1'b0;
        chk(done === 1'b1 && lcd_cs_n === 1'b1 && busy === 1'b0, "R7 done with cs high", {done, lcd_cs_n, busy}, 3'b110);
        chk(busy_err == 0, "R7 busy tracks cs", busy_err, 0);
        @(negedge clk);
        chk(done === 1'b0, "R7 done single pulse", done, 0);
    endtask

    task automatic t_reset;
        chk(lcd_cs_n && lcd_wr_n && lcd_rd_n && lcd_rs && !lcd_dout_en, "R8 pins idle",
            {lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_rs, lcd_dout_en}, 5'b11110);
        chk(!busy && !done && rd_word == 16'h0, "R8 status zero", {busy, done, rd_word}, 0);
    endtask

    task automatic t_index_write;
        run_op(2'b00, 16'h0023, 16'h2212, 0);
        chk(cap_rs == 1'b0, "R3 index rs low", cap_rs, 0);
        chk(cur_idx == 8'h23, "R3 index stored", cur_idx, 8'h23);
        chk(n_setup == 3 && n_wr == 3 && n_hold == 2, "R4 command timing",
            n_setup * 100 + n_wr * 10 + n_hold, 332);
        chk(cap_bus == pack_ref(16'h0023), "R1 index packing", cap_bus, pack_ref(16'h0023));
    endtask

    task automatic t_data_write;
        run_op(2'b01, 16'hA55A, 16'h3102, 0);
        chk(cap_rs == 1'b1, "R3 data rs high", cap_rs, 1);
        chk(panel_regs[8'h23] == 16'hA55A, "R3 data stored", panel_regs[8'h23], 16'hA55A);
        chk(n_setup == 2 && n_wr == 2 && n_hold == 4, "R4 data timing R9 captured",
            n_setup * 100 + n_wr * 10 + n_hold, 224);
        chk(cap_bus == 18'h294B4 && cap_bus[0] == 1'b0 && cap_bus[9] == 1'b0, "R1 data packing",
            cap_bus, 18'h294B4);
    endtask

    task automatic t_read;
        panel_regs[8'h40] = 16'h9C3E;
        run_op(2'b10, 16'h0040, 16'h2311, 0);
        chk(cap_rs == 1'b0 && cur_idx == 8'h40, "R5 read index phase", cur_idx, 8'h40);
        chk(n_setup == 2 && n_wr == 2 && n_hold == 2, "R5 read index timing",
            n_setup * 100 + n_wr * 10 + n_hold, 222);
        chk(n_turn == 1 && n_rd == 4 && n_rdhold == 3, "R5 read strobe timing",
            n_turn * 100 + n_rd * 10 + n_rdhold, 143);
        chk(oe_clash == 0 && n_turn >= 1, "R6 bus released before read", oe_clash, 0);
        chk(rd_word == 16'h9C3E, "R2 unpacked read", rd_word, 16'h9C3E);
    endtask

    task automatic t_zero_timing;
        run_op(2'b01, 16'h00FF, 16'h0000, 0);
        chk(n_setup == 1 && n_wr == 1 && n_hold == 1, "R4 minimum phases",
            n_setup * 100 + n_wr * 10 + n_hold, 111);
        chk(rd_word == 16'h9C3E, "R9 rd_word kept over write", rd_word, 16'h9C3E);
        panel_regs[8'h07] = 16'h0180;
        run_op(2'b11, 16'h0007, 16'h0000, 0);
        chk(n_turn == 1 && n_rd == 1 && n_rdhold == 1, "R5 minimum read phases",
            n_turn * 100 + n_rd * 10 + n_rdhold, 111);
        chk(rd_word == 16'h0180, "R3 op 11 reads", rd_word, 16'h0180);
    endtask

    task automatic t_ignore_busy;
        run_op(2'b01, 16'h1111, 16'h0201, 1);
        chk(panel_regs[8'h07] == 16'h1111, "R7 running write completes", panel_regs[8'h07], 16'h1111);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(lcd_cs_n === 1'b1 && busy === 1'b0, "R7 request while busy ignored", {lcd_cs_n, busy}, 2'b10);
        end
        chk(cur_idx == 8'h07, "R7 index untouched", cur_idx, 8'h07);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) panel_regs[i] = 16'h0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_index_write();
        t_data_write();
        t_read();
        t_zero_timing();
        t_ignore_busy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule